// File: doc/BRIEF.md
# Reset Cause Capture Register

This block keeps a record of why a small processor core last restarted or woke. It receives single-cycle strobes for each possible cause: power-on, brown-out, the external reset pin, watchdog expiry, watchdog wake, window-watchdog violation, the software reset instruction, stack overflow and underflow, interrupt wake, and regulator-ready fault. From these it maintains an 8-bit cause register, a timeout flag, a power-down flag and a restart-address select.

Most cause bits are active-low: an event drives its bit to 0. The two stack-fault bits are active-high: an event drives them to 1. Power-on, brown-out and the regulator fault reload most of the register at once. Every other cause changes only its own bit. Firmware reads the register after a restart. It then writes inactive values back, so that the next event can be seen. The restart select tells the fetch logic whether to start at address zero or to resume at PC+2 after a wake.

Top module: `rst_cause_rec`

## Requirements
- R1: While `rst` is high at a clock edge, and on a power-on strobe, the outputs become: `cause_q` = 8'h3C, `to_q` = 1, `pd_q` = 1, `resume_pc2` = 0. The undefined brown-out bit is loaded as 0.
- R2: The cause bit positions are: 7 stack overflow, 6 stack underflow, 5 window violation, 4 watchdog timeout, 3 pin reset, 2 software reset, 1 power-on, 0 brown-out. A brown-out strobe loads bits 7..2 with 001111, keeps bit 1, clears bit 0, and sets `to_q` and `pd_q` to 1.
- R3: A regulator fault strobe loads bits 7..1 with 0011001, keeps bit 0, and sets `to_q` and `pd_q` to 1.
- R4: A pin reset clears only bit 3. A watchdog timeout clears only bit 4. A window violation clears only bit 5. A software reset clears only bit 2.
- R5: When `stk_rst_en` is 1, a stack overflow strobe sets bit 7 and a stack underflow strobe sets bit 6. When `stk_rst_en` is 0, both strobes have no effect on any output.
- R6: The flags update as follows:
  - A pin reset with `asleep` = 1 sets `to_q` = 1 and `pd_q` = 0. With `asleep` = 0 it leaves both flags unchanged.
  - A watchdog timeout clears `to_q` and keeps `pd_q`.
  - A watchdog wake clears both flags and leaves `cause_q` unchanged.
  - An interrupt wake sets `to_q` = 1 and `pd_q` = 0.
- R7: Any reset event sets `resume_pc2` to 0. A wake event with no reset event in the same cycle sets `resume_pc2` to 1. A cycle with neither event holds `resume_pc2`.
- R8: Among the full reloads, power-on takes priority over brown-out, and brown-out over the regulator fault; only the highest one applies. Partial updates then merge onto its result. When flag updates conflict, the watchdog events win for `to_q`.
- R9: A write with `sw_we` = 1 loads `cause_q` with `sw_wdata`. Any bit that an event touches in the same cycle takes the event's value instead.
- R10: All outputs are registered and change at the clock edge that samples the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| asleep | input | 1 | Core is in sleep mode |
| stk_rst_en | input | 1 | Enables the stack-fault reset strobes |
| ev_por | input | 1 | Power-on strobe |
| ev_bor | input | 1 | Brown-out strobe |
| ev_vreg | input | 1 | Regulator-ready fault strobe |
| ev_pin | input | 1 | External reset pin strobe |
| ev_wdt_to | input | 1 | Watchdog timeout reset strobe |
| ev_wdt_wake | input | 1 | Watchdog wake-from-sleep strobe |
| ev_win | input | 1 | Window-watchdog violation strobe |
| ev_swrst | input | 1 | Software reset instruction strobe |
| ev_ovf | input | 1 | Stack overflow strobe |
| ev_unf | input | 1 | Stack underflow strobe |
| ev_irq_wake | input | 1 | Interrupt wake-from-sleep strobe |
| sw_we | input | 1 | Software write enable for the cause register |
| sw_wdata | input | 8 | Software write data |
| cause_q | output | 8 | Cause register |
| to_q | output | 1 | Timeout flag |
| pd_q | output | 1 | Power-down flag |
| resume_pc2 | output | 1 | 1 = resume at PC+2, 0 = restart at address zero |

## Verification
Two kinds of update can land in the same cycle: a software write and a hardware event, or a full reload and a partial update. The bench strobes these pairs together: a write of 8'h3F with a watchdog timeout, and a write of 8'h00 with an enabled overflow. It also pairs power-on with pin and watchdog strobes, and brown-out with a regulator fault. Each result is judged against the merged value worked out from R8 and R9. For example, power-on with pin and watchdog strobes gives 8'h24, and brown-out over a prior 8'h3D gives 8'h3C rather than the regulator's 8'h33.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
  localparam int CW = 8;

  // bit positions inside the cause register
  localparam int B_OVF = 7;
  localparam int B_UNF = 6;
  localparam int B_WIN = 5;
  localparam int B_WDT = 4;
  localparam int B_PIN = 3;
  localparam int B_SW  = 2;
  localparam int B_POR = 1;
  localparam int B_BOR = 0;

  localparam logic [CW-1:0] POR_LOAD = 8'h3C;
  localparam logic [CW-3:0] BOR_HI   = 6'b001111;
  localparam logic [CW-2:0] VREG_HI  = 7'b0011001;

  localparam int NCLR = 4;

  typedef struct packed {
    logic por;
    logic bor;
    logic vreg;
    logic pin;
    logic wdt_to;
    logic wdt_wake;
    logic win;
    logic swrst;
    logic ovf;
    logic unf;
    logic irq_wake;
  } ev_t;
endpackage

// File: rtl/rcr_cause_next.sv
module rcr_cause_next
  import rcr_pkg::*;
(
  input  logic [CW-1:0] cause_q,
  input  logic          por,
  input  logic          bor,
  input  logic          vreg,
  input  logic          pin,
  input  logic          wdt_to,
  input  logic          win,
  input  logic          swrst,
  input  logic          ovf,
  input  logic          unf,
  input  logic          stk_en,
  input  logic          sw_we,
  input  logic [CW-1:0] sw_wdata,
  output logic [CW-1:0] cause_d
);
  logic [CW-1:0]   base;
  logic [CW-1:0]   full;
  logic [NCLR-1:0] clr_hit;
  int              clr_pos [NCLR];

  assign clr_hit = {swrst, pin, wdt_to, win};

  always_comb begin
    clr_pos[0] = B_WIN;
    clr_pos[1] = B_WDT;
    clr_pos[2] = B_PIN;
    clr_pos[3] = B_SW;
  end

  always_comb begin
    base = sw_we ? sw_wdata : cause_q;
    if (por)       full = POR_LOAD;
    else if (bor)  full = {BOR_HI, base[B_POR], 1'b0};
    else if (vreg) full = {VREG_HI, base[B_BOR]};
    else           full = base;
    cause_d = full;
    for (int i = 0; i < NCLR; i++)
      if (clr_hit[i]) cause_d[clr_pos[i]] = 1'b0;
    if (stk_en && ovf) cause_d[B_OVF] = 1'b1;
    if (stk_en && unf) cause_d[B_UNF] = 1'b1;
  end
endmodule

// File: rtl/rcr_flag_next.sv
module rcr_flag_next
  import rcr_pkg::*;
(
  input  rcr_pkg::ev_t ev,
  input  logic         asleep,
  input  logic         stk_en,
  input  logic         to_q,
  input  logic         pd_q,
  input  logic         rs_q,
  output logic         to_d,
  output logic         pd_d,
  output logic         rs_d,
  output logic         any_rst
);
  logic full_ld;
  logic pin_sl;
  logic any_wake;

  assign full_ld  = ev.por | ev.bor | ev.vreg;
  assign pin_sl   = ev.pin & asleep;
  assign any_wake = ev.wdt_wake | ev.irq_wake;
  assign any_rst  = full_ld | ev.pin | ev.wdt_to | ev.win | ev.swrst
                  | (stk_en & (ev.ovf | ev.unf));

  always_comb begin
    to_d = full_ld ? 1'b1 : to_q;
    pd_d = full_ld ? 1'b1 : pd_q;
    if (pin_sl || ev.irq_wake) begin
      to_d = 1'b1;
      pd_d = 1'b0;
    end
    if (ev.wdt_wake) pd_d = 1'b0;
    if (ev.wdt_wake || ev.wdt_to) to_d = 1'b0;
    if (any_rst)       rs_d = 1'b0;
    else if (any_wake) rs_d = 1'b1;
    else               rs_d = rs_q;
  end
endmodule

// File: rtl/rst_cause_rec.sv
module rst_cause_rec
  import rcr_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          asleep,
  input  logic          stk_rst_en,
  input  logic          ev_por,
  input  logic          ev_bor,
  input  logic          ev_vreg,
  input  logic          ev_pin,
  input  logic          ev_wdt_to,
  input  logic          ev_wdt_wake,
  input  logic          ev_win,
  input  logic          ev_swrst,
  input  logic          ev_ovf,
  input  logic          ev_unf,
  input  logic          ev_irq_wake,
  input  logic          sw_we,
  input  logic [CW-1:0] sw_wdata,
  output logic [CW-1:0] cause_q,
  output logic          to_q,
  output logic          pd_q,
  output logic          resume_pc2
);
  ev_t           ev;
  logic [CW-1:0] cause_d;
  logic          to_d, pd_d, rs_d, any_rst;

  assign ev = '{por: ev_por, bor: ev_bor, vreg: ev_vreg, pin: ev_pin,
                wdt_to: ev_wdt_to, wdt_wake: ev_wdt_wake, win: ev_win,
                swrst: ev_swrst, ovf: ev_ovf, unf: ev_unf,
                irq_wake: ev_irq_wake};

  rcr_cause_next u_cause (
    .cause_q (cause_q),
    .por     (ev_por),
    .bor     (ev_bor),
    .vreg    (ev_vreg),
    .pin     (ev_pin),
    .wdt_to  (ev_wdt_to),
    .win     (ev_win),
    .swrst   (ev_swrst),
    .ovf     (ev_ovf),
    .unf     (ev_unf),
    .stk_en  (stk_rst_en),
    .sw_we   (sw_we),
    .sw_wdata(sw_wdata),
    .cause_d (cause_d)
  );

  rcr_flag_next u_flag (
    .ev     (ev),
    .asleep (asleep),
    .stk_en (stk_rst_en),
    .to_q   (to_q),
    .pd_q   (pd_q),
    .rs_q   (resume_pc2),
    .to_d   (to_d),
    .pd_d   (pd_d),
    .rs_d   (rs_d),
    .any_rst(any_rst)
  );

  // R1 / R10: registered state, synchronous reset
  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q    <= POR_LOAD;
      to_q       <= 1'b1;
      pd_q       <= 1'b1;
      resume_pc2 <= 1'b0;
    end else begin
      cause_q    <= cause_d;
      to_q       <= to_d;
      pd_q       <= pd_d;
      resume_pc2 <= rs_d;
    end
  end

  a_r4_pin_clears: assert property (@(posedge clk) disable iff (rst)
    ev_pin |=> !cause_q[B_PIN]);

  a_r5_stk_ignored: assert property (@(posedge clk) disable iff (rst)
    (!stk_rst_en && (ev_ovf || ev_unf) && !sw_we && !ev_por && !ev_bor &&
     !ev_vreg && !ev_pin && !ev_wdt_to && !ev_wdt_wake && !ev_win &&
     !ev_swrst && !ev_irq_wake)
    |=> ($stable(cause_q) && $stable(to_q) && $stable(pd_q) && $stable(resume_pc2)));

  a_r7_reset_vec0: assert property (@(posedge clk) disable iff (rst)
    (ev_por || ev_bor || ev_pin || ev_win || ev_swrst) |=> !resume_pc2);

  a_r7_wake_resume: assert property (@(posedge clk) disable iff (rst)
    (ev_irq_wake && !any_rst) |=> resume_pc2);

  a_r6_wdt_wake_flags: assert property (@(posedge clk) disable iff (rst)
    ev_wdt_wake |=> (!to_q && !pd_q));

  a_r1_por_load: assert property (@(posedge clk) disable iff (rst)
    (ev_por && !ev_pin && !ev_wdt_to && !ev_win && !ev_swrst &&
     !(stk_rst_en && (ev_ovf || ev_unf)))
    |=> (cause_q == POR_LOAD));
endmodule

// File: tb/tb_rst_cause_rec.sv
module tb_rst_cause_rec;
  localparam int E_POR = 0, E_BOR = 1, E_VREG = 2, E_PIN = 3, E_WDT = 4,
                 E_WWK = 5, E_WIN = 6, E_SW = 7, E_OVF = 8, E_UNF = 9,
                 E_IRQ = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       asleep = 1'b0, stk_rst_en = 1'b0;
  logic [10:0] ev = '0;
  logic       sw_we = 1'b0;
  logic [7:0] sw_wdata = '0;
  logic [7:0] cause_q;
  logic       to_q, pd_q, resume_pc2;
  int         checks = 0;
  int         errors = 0;

  always #2 clk = ~clk;

  rst_cause_rec dut (
    .clk(clk), .rst(rst), .asleep(asleep), .stk_rst_en(stk_rst_en),
    .ev_por(ev[E_POR]), .ev_bor(ev[E_BOR]), .ev_vreg(ev[E_VREG]),
    .ev_pin(ev[E_PIN]), .ev_wdt_to(ev[E_WDT]), .ev_wdt_wake(ev[E_WWK]),
    .ev_win(ev[E_WIN]), .ev_swrst(ev[E_SW]), .ev_ovf(ev[E_OVF]),
    .ev_unf(ev[E_UNF]), .ev_irq_wake(ev[E_IRQ]),
    .sw_we(sw_we), .sw_wdata(sw_wdata),
    .cause_q(cause_q), .to_q(to_q), .pd_q(pd_q), .resume_pc2(resume_pc2)
  );

  task automatic chk(input logic [7:0] ec, input logic et, input logic ep,
                     input logic er, input string req);
    checks++;
    if (cause_q !== ec || to_q !== et || pd_q !== ep || resume_pc2 !== er) begin
      errors++;
      $display("FAIL %s: got cause=%h to=%b pd=%b rs=%b, expected cause=%h to=%b pd=%b rs=%b",
               req, cause_q, to_q, pd_q, resume_pc2, ec, et, ep, er);
    end
  endtask

  task automatic fire(input logic [10:0] e, input logic sl, input logic en,
                      input logic we, input logic [7:0] wd);
    @(negedge clk);
    ev = e; asleep = sl; stk_rst_en = en; sw_we = we; sw_wdata = wd;
    @(negedge clk);
    ev = '0; asleep = 1'b0; stk_rst_en = 1'b0; sw_we = 1'b0; sw_wdata = '0;
  endtask

  function automatic logic [10:0] one(input int b);
    logic [10:0] v = '0;
    v[b] = 1'b1;
    return v;
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk(8'h3C, 1, 1, 0, "R1 reset");
  endtask

  task automatic t_write_and_partials();
    fire('0, 0, 0, 1, 8'h3F);          chk(8'h3F, 1, 1, 0, "R9 write");
    fire(one(E_PIN), 0, 0, 0, 0);      chk(8'h37, 1, 1, 0, "R4 R6 pin running");
    fire('0, 0, 0, 1, 8'h3F);
    fire(one(E_WDT), 0, 0, 0, 0);      chk(8'h2F, 0, 1, 0, "R4 R6 wdt timeout");
    fire(one(E_WWK), 0, 0, 0, 0);      chk(8'h2F, 0, 0, 1, "R6 R7 wdt wake");
    @(negedge clk);                    chk(8'h2F, 0, 0, 1, "R7 hold");
    fire(one(E_IRQ), 0, 0, 0, 0);      chk(8'h2F, 1, 0, 1, "R6 R7 irq wake");
    fire(one(E_PIN), 1, 0, 0, 0);      chk(8'h27, 1, 0, 0, "R6 pin asleep");
    fire(one(E_WIN), 0, 0, 0, 0);      chk(8'h07, 1, 0, 0, "R4 window");
    fire(one(E_SW), 0, 0, 0, 0);       chk(8'h03, 1, 0, 0, "R4 swrst");
  endtask

  task automatic t_stack();
    fire(one(E_IRQ), 0, 0, 0, 0);
    fire(one(E_OVF) | one(E_UNF), 0, 0, 0, 0);
    chk(8'h03, 1, 0, 1, "R5 stack ignored");
    fire(one(E_OVF), 0, 1, 0, 0);      chk(8'h83, 1, 0, 0, "R5 overflow");
    fire(one(E_UNF), 0, 1, 0, 0);      chk(8'hC3, 1, 0, 0, "R5 underflow");
  endtask

  task automatic t_full_loads();
    fire(one(E_BOR), 0, 0, 0, 0);      chk(8'h3E, 1, 1, 0, "R2 brown-out");
    fire('0, 0, 0, 1, 8'h3D);
    fire(one(E_VREG), 0, 0, 0, 0);     chk(8'h33, 1, 1, 0, "R3 vreg fault");
    fire('0, 0, 0, 1, 8'h3D);
    fire(one(E_BOR) | one(E_VREG), 0, 0, 0, 0);
    chk(8'h3C, 1, 1, 0, "R8 bor over vreg");
    fire('0, 0, 0, 1, 8'h3D);
    fire(one(E_POR) | one(E_VREG), 0, 0, 0, 0);
    chk(8'h3C, 1, 1, 0, "R8 por over vreg");
    fire(one(E_POR) | one(E_PIN) | one(E_WDT), 0, 0, 0, 0);
    chk(8'h24, 0, 1, 0, "R8 merge onto por");
  endtask

  task automatic t_collisions();
    fire(one(E_WDT), 0, 0, 1, 8'h3F);  chk(8'h2F, 0, 1, 0, "R9 event beats write");
    fire(one(E_OVF), 0, 1, 1, 8'h00);  chk(8'h80, 0, 1, 0, "R9 ovf beats write");
    fire(one(E_IRQ), 0, 0, 0, 0);
    fire(one(E_WDT) | one(E_IRQ), 0, 0, 0, 0);
    chk(8'h80, 0, 0, 0, "R7 R8 wdt vs irq");
    fire(one(E_POR), 0, 0, 0, 0);      chk(8'h3C, 1, 1, 0, "R1 por strobe");
    fire('0, 0, 0, 1, 8'h11);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(8'h3C, 1, 1, 0, "R1 R10 late reset");
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_write_and_partials();
    t_stack();
    t_full_loads();
    t_collisions();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule